// File: doc/BRIEF.md
# Chained Block Transfer Controller

This controller runs a list of transfer commands that software leaves in system memory, moving whole blocks between its own internal block store and memory buffers. Software builds the list, writes the byte address of its first entry into the start register, and is free until the single completion interrupt. Between entries the controller follows the link word of each entry on its own, so block reads and block writes can be mixed in any order inside one list.

Each list entry is four consecutive 32-bit words: an operation word, a block number, a buffer byte address and a link to the following entry. A block is 512 bytes (128 words). Before the first word of every block moves, the controller waits a fixed latency that stands in for the medium's access time. A block number that does not exist in the store stops the list, flags an error and still raises the interrupt, so software always gets exactly one completion event per start.

Top module: `cbd_ctrl`

## Requirements
- R1: An entry at byte address P is fetched from P, P+4, P+8 and P+12 as, in that order, the operation word, the block number, the buffer byte address and the link; a link of zero makes that entry the last one.
- R2: Operation word bit 0 equal to 0 copies all 128 words of the named store block into the buffer, block word i landing at buffer address + 4*i; the other bits of the operation word are ignored.
- R3: Operation word bit 0 equal to 1 copies the 128 buffer words into the named store block, so a later copy of that block out to memory returns the same words.
- R4: Entries run in list order with no software action between them, and an entry sees the store contents that every earlier entry of the same list left behind.
- R5: Status register (offset 1) bit 0 reads 1 from the cycle after an accepted start until the list has finished, and 0 otherwise.
- R6: A write to offset 0 while idle stores the list head (readable at offset 0) and starts the list; a write to offset 0 while bit 0 of status is 1 changes neither the head nor the running list.
- R7: irq_o rises exactly once per accepted start, at the same clock edge on which status bit 0 falls, is mirrored in status bit 1, and stays high until software writes offset 1 with bit 1 set or starts a new list.
- R8: An entry whose block number is not below the store size ends the list without touching memory or the store; status bit 2 is then set and offset 2 holds the zero-based index of that entry. A new start clears bit 2 and offset 2.
- R9: Offset 3 reads the number of entries completed by the most recent list.
- R10: A start with a head of zero issues no memory request, completes with no error and a count of zero, and still raises irq_o.
- R11: A memory request that sees mem_ready_i low is held, with address, direction and write data unchanged, until mem_ready_i is high; list contents and copies come out the same whatever the ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 head, 1 status, 2 failing entry, 3 completed count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq_o | output | 1 | Completion interrupt, level |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i on a read |

## Verification
Register reads are combinational and are sampled one time step after the bench sets the index; status bit 0 is due at the first sampling point after the edge that accepts the start, so the bench checks it there, and then keeps a per-cycle reference flag that must match bit 0 and irq_o until completion. Completion time depends on the ready pattern, so the bench waits for irq_o with a bound and only then compares status, failing index, count and its behavioural image of the whole memory, which it updates by walking the same list over its own copy of the store. Interrupt rises and memory request cycles are counted on every clock, which makes the single-interrupt rule and the zero-head rule checkable at the ports.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

    localparam int BLOCK_BYTES = 512;
    localparam int WORD_BYTES  = 4;
    localparam int BLK_WORDS   = BLOCK_BYTES / WORD_BYTES;
    localparam int NODE_WORDS  = 4;

    // register indices
    localparam logic [1:0] RIX_HEAD = 2'd0;
    localparam logic [1:0] RIX_STAT = 2'd1;
    localparam logic [1:0] RIX_FAIL = 2'd2;
    localparam logic [1:0] RIX_CNT  = 2'd3;

    // status bit positions
    localparam int SB_BUSY = 0;
    localparam int SB_IRQ  = 1;
    localparam int SB_ERR  = 2;

    typedef enum logic [3:0] {
        E_IDLE,
        E_FETCH,
        E_CHECK,
        E_SEEK,
        E_RD_LOAD,
        E_RD_PUT,
        E_WR_GET,
        E_NODE_END,
        E_FINISH
    } eng_state_e;

    typedef struct packed {
        logic [31:0] opw;
        logic [31:0] blk;
        logic [31:0] buf_a;
        logic [31:0] link;
    } node_t;

endpackage

// File: rtl/cbd_store.sv
module cbd_store #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          re_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    output logic [31:0]   rdata_o
);

    logic [31:0] cells_q [DEPTH];
    logic [31:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[addr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= cells_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/cbd_engine.sv
module cbd_engine
    import cbd_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int BLOCK_LAT  = 8,
    parameter int ST_AW      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [31:0]      head_i,
    output logic             busy_o,
    output logic             err_o,
    output logic [31:0]      fail_idx_o,
    output logic [31:0]      done_cnt_o,
    output logic             fin_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [31:0]      mem_addr_o,
    output logic [31:0]      mem_wdata_o,
    input  logic             mem_ready_i,
    input  logic [31:0]      mem_rdata_i,
    output logic             st_re_o,
    output logic             st_we_o,
    output logic [ST_AW-1:0] st_addr_o,
    output logic [31:0]      st_wdata_o,
    input  logic [31:0]      st_rdata_i
);

    localparam int WORD_W = $clog2(BLK_WORDS);
    localparam int BLK_W  = ST_AW - WORD_W;
    localparam int LAT_W  = $clog2(BLOCK_LAT + 1);
    localparam int KW     = $clog2(NODE_WORDS);

    typedef struct packed {
        eng_state_e         st;
        logic               busy;
        logic               err;
        logic [31:0]        fail_idx;
        logic [31:0]        cnt;
        logic [31:0]        ptr;
        node_t              node;
        logic [KW-1:0]      k;
        logic [LAT_W-1:0]   lat;
        logic [WORD_W-1:0]  w;
    } eng_reg_t;

    eng_reg_t q, d;

    logic [31:0] node_base;
    logic [31:0] buf_word_addr;
    logic        last_word;

    assign node_base     = {q.ptr[31:2], 2'b00} + {{(30-KW){1'b0}}, q.k, 2'b00};
    assign buf_word_addr = {q.node.buf_a[31:2], 2'b00} + {{(30-WORD_W){1'b0}}, q.w, 2'b00};
    assign last_word     = (q.w == WORD_W'(BLK_WORDS - 1));

    always_comb begin
        d           = q;
        fin_o       = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = st_rdata_i;
        st_re_o     = 1'b0;
        st_we_o     = 1'b0;
        st_addr_o   = {q.node.blk[BLK_W-1:0], q.w};
        st_wdata_o  = mem_rdata_i;

        unique case (q.st)
            E_IDLE: begin
                if (go_i) begin
                    d.busy     = 1'b1;
                    d.err      = 1'b0;
                    d.fail_idx = '0;
                    d.cnt      = '0;
                    d.ptr      = head_i;
                    d.k        = '0;
                    d.st       = (head_i == 32'd0) ? E_FINISH : E_FETCH;
                end
            end
            E_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = node_base;
                if (mem_ready_i) begin
                    case (q.k)
                        KW'(0):  d.node.opw   = mem_rdata_i;
                        KW'(1):  d.node.blk   = mem_rdata_i;
                        KW'(2):  d.node.buf_a = mem_rdata_i;
                        default: d.node.link  = mem_rdata_i;
                    endcase
                    if (q.k == KW'(NODE_WORDS - 1)) begin
                        d.st = E_CHECK;
                    end else begin
                        d.k = q.k + KW'(1);
                    end
                end
            end
            E_CHECK: begin
                if (q.node.blk >= 32'(NUM_BLOCKS)) begin
                    d.err      = 1'b1;
                    d.fail_idx = q.cnt;
                    d.st       = E_FINISH;
                end else begin
                    d.lat = '0;
                    d.w   = '0;
                    d.st  = E_SEEK;
                end
            end
            E_SEEK: begin
                if (q.lat == LAT_W'(BLOCK_LAT - 1)) begin
                    d.st = q.node.opw[0] ? E_WR_GET : E_RD_LOAD;
                end else begin
                    d.lat = q.lat + LAT_W'(1);
                end
            end
            E_RD_LOAD: begin
                st_re_o = 1'b1;
                d.st    = E_RD_PUT;
            end
            E_RD_PUT: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = buf_word_addr;
                if (mem_ready_i) begin
                    if (last_word) begin
                        d.st = E_NODE_END;
                    end else begin
                        d.w  = q.w + WORD_W'(1);
                        d.st = E_RD_LOAD;
                    end
                end
            end
            E_WR_GET: begin
                mem_req_o  = 1'b1;
                mem_addr_o = buf_word_addr;
                if (mem_ready_i) begin
                    st_we_o = 1'b1;
                    if (last_word) begin
                        d.st = E_NODE_END;
                    end else begin
                        d.w = q.w + WORD_W'(1);
                    end
                end
            end
            E_NODE_END: begin
                d.cnt = q.cnt + 32'd1;
                if (q.node.link == 32'd0) begin
                    d.st = E_FINISH;
                end else begin
                    d.ptr = q.node.link;
                    d.k   = '0;
                    d.st  = E_FETCH;
                end
            end
            E_FINISH: begin
                fin_o  = 1'b1;
                d.busy = 1'b0;
                d.st   = E_IDLE;
            end
            default: begin
                d.st = E_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: E_IDLE, node: '0, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = q.busy;
    assign err_o      = q.err;
    assign fail_idx_o = q.fail_idx;
    assign done_cnt_o = q.cnt;

    AST_FIN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o); // R7

    AST_STORE_WRITE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        st_we_o |-> (busy_o && !err_o && mem_ready_i)); // R8

endmodule

// File: rtl/cbd_regs.sv
module cbd_regs
    import cbd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy_i,
    input  logic        err_i,
    input  logic [31:0] fail_idx_i,
    input  logic [31:0] done_cnt_i,
    input  logic        fin_i,
    output logic        go_o,
    output logic [31:0] head_o,
    output logic        irq_o
);

    typedef struct packed {
        logic [31:0] head;
        logic        irq;
    } csr_reg_t;

    csr_reg_t q, d;

    always_comb begin
        d    = q;
        go_o = reg_we && (reg_addr == RIX_HEAD) && !busy_i;

        if (go_o) begin
            d.head = reg_wdata;
            d.irq  = 1'b0;
        end
        if (reg_we && (reg_addr == RIX_STAT) && reg_wdata[SB_IRQ]) begin
            d.irq = 1'b0;
        end
        if (fin_i) begin
            d.irq = 1'b1;
        end

        unique case (reg_addr)
            RIX_HEAD: reg_rdata = q.head;
            RIX_STAT: begin
                reg_rdata          = '0;
                reg_rdata[SB_BUSY] = busy_i;
                reg_rdata[SB_IRQ]  = q.irq;
                reg_rdata[SB_ERR]  = err_i;
            end
            RIX_FAIL: reg_rdata = fail_idx_i;
            default:  reg_rdata = done_cnt_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_o = q.head;
    assign irq_o  = q.irq;

    AST_START_WHILE_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == RIX_HEAD) && busy_i) |=> $stable(head_o)); // R6

endmodule

// File: rtl/cbd_ctrl.sv
module cbd_ctrl
    import cbd_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int BLOCK_LAT  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ready_i,
    input  logic [31:0] mem_rdata_i
);

    localparam int BLK_W    = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
    localparam int WORD_W   = $clog2(BLK_WORDS);
    localparam int ST_AW    = BLK_W + WORD_W;
    localparam int ST_DEPTH = NUM_BLOCKS * BLK_WORDS;

    logic             go_w;
    logic [31:0]      head_w;
    logic             busy_w;
    logic             err_w;
    logic [31:0]      fail_w;
    logic [31:0]      cnt_w;
    logic             fin_w;
    logic             st_re_w;
    logic             st_we_w;
    logic [ST_AW-1:0] st_addr_w;
    logic [31:0]      st_wdata_w;
    logic [31:0]      st_rdata_w;

    cbd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy_w),
        .err_i      (err_w),
        .fail_idx_i (fail_w),
        .done_cnt_i (cnt_w),
        .fin_i      (fin_w),
        .go_o       (go_w),
        .head_o     (head_w),
        .irq_o      (irq_o)
    );

    cbd_engine #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLOCK_LAT  (BLOCK_LAT),
        .ST_AW      (ST_AW)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go_w),
        .head_i      (reg_wdata),
        .busy_o      (busy_w),
        .err_o       (err_w),
        .fail_idx_o  (fail_w),
        .done_cnt_o  (cnt_w),
        .fin_o       (fin_w),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ready_i (mem_ready_i),
        .mem_rdata_i (mem_rdata_i),
        .st_re_o     (st_re_w),
        .st_we_o     (st_we_w),
        .st_addr_o   (st_addr_w),
        .st_wdata_o  (st_wdata_w),
        .st_rdata_i  (st_rdata_w)
    );

    cbd_store #(
        .DEPTH (ST_DEPTH),
        .AW    (ST_AW)
    ) u_store (
        .clk     (clk),
        .re_i    (st_re_w),
        .we_i    (st_we_w),
        .addr_i  (st_addr_w),
        .wdata_i (st_wdata_w),
        .rdata_o (st_rdata_w)
    );

    AST_IRQ_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !busy_w); // R7

    AST_IRQ_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_w) |-> $rose(irq_o)); // R7

    AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) &&
             (!mem_we_o || $stable(mem_wdata_o)))); // R11

    AST_HEAD_TRACKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        go_w |=> (head_w == $past(reg_wdata))); // R6

endmodule

// File: tb/cbd_ctrl_tb.sv
module cbd_ctrl_tb_top;
    import cbd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4;
    localparam int LAT        = 8;
    localparam int MEMW       = 4096;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = RIX_STAT;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ready_i;
    logic [31:0] mem_rdata_i;

    logic [31:0] mem [MEMW];
    logic [31:0] exp_mem [MEMW];
    logic [31:0] exp_store [NB*BLK_WORDS];

    logic [7:0]  lf = 8'h5A;
    bit          stall_en = 1'b0;
    bit          run_active = 1'b0;
    int          nchk = 0, nfail = 0, cyc = 0;
    int          irq_rises = 0, req_cycles = 0;
    logic        irq_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbd_ctrl #(.NUM_BLOCKS(NB), .BLOCK_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
    );

    assign mem_ready_i = !stall_en || lf[0] || lf[3];
    assign mem_rdata_i = mem[mem_addr_o[13:2]];

    always @(posedge clk) begin
        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        if (mem_req_o && mem_we_o && mem_ready_i) mem[mem_addr_o[13:2]] <= mem_wdata_o;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // per-clock reference comparison, a quarter period after the edge
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (rst_n) begin
            if (mem_req_o) req_cycles++;
            if (irq_o && !irq_prev) irq_rises++;
            irq_prev = irq_o;
            if (reg_addr == RIX_STAT && !reg_we) begin
                // R7: status mirrors irq, busy and irq never together
                check(reg_rdata[SB_IRQ] == irq_o, "R7 irq mirror", {31'd0, reg_rdata[SB_IRQ]}, {31'd0, irq_o});
                check(!(irq_o && reg_rdata[SB_BUSY]), "R7 irq while busy", reg_rdata, 32'd2);
                // R5: busy held for the whole run until completion
                if (run_active && !irq_o)
                    check(reg_rdata[SB_BUSY] == 1'b1, "R5 busy during run", reg_rdata, 32'd1);
            end
        end
    end

    function automatic logic [31:0] pat(input int seed, input int w);
        return (32'(seed) * 32'h0100_0193) ^ (32'(w) * 32'h9E37_79B1) ^ 32'h0F0F_A5A5;
    endfunction

    task automatic put(input logic [31:0] byte_addr, input logic [31:0] v);
        mem[byte_addr[13:2]]     = v;
        exp_mem[byte_addr[13:2]] = v;
    endtask

    task automatic fill_buf(input logic [31:0] base, input int seed);
        for (int w = 0; w < BLK_WORDS; w++) put(base + 32'(4*w), pat(seed, w));
    endtask

    task automatic put_node(input logic [31:0] at, input logic [31:0] op,
                            input logic [31:0] blk, input logic [31:0] bufa, input logic [31:0] link);
        put(at, op); put(at + 4, blk); put(at + 8, bufa); put(at + 12, link);
    endtask

    // behavioural walk of a list over the bench's own memory and store images
    task automatic model_run(input logic [31:0] head, output bit e_err,
                             output int e_fail, output int e_cnt);
        logic [31:0] p = head;
        e_err = 0; e_fail = 0; e_cnt = 0;
        for (int guard = 0; guard < 64 && p != 0; guard++) begin
            logic [31:0] op, blk, bufa, nxt;
            op   = exp_mem[p[13:2]];
            blk  = exp_mem[p[13:2] + 1];
            bufa = exp_mem[p[13:2] + 2];
            nxt  = exp_mem[p[13:2] + 3];
            if (blk >= NB) begin
                e_err = 1; e_fail = e_cnt;
                break;
            end
            for (int w = 0; w < BLK_WORDS; w++) begin
                if (op[0]) exp_store[blk*BLK_WORDS + w] = exp_mem[bufa[13:2] + 12'(w)];
                else       exp_mem[bufa[13:2] + 12'(w)] = exp_store[blk*BLK_WORDS + w];
            end
            e_cnt++;
            p = nxt;
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = RIX_STAT;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = RIX_STAT;
    endtask

    task automatic compare_mem(input string tag);
        int bad = 0, first = -1;
        for (int i = 0; i < MEMW; i++)
            if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
        check(bad == 0, tag, 32'(bad), 32'd0);
        if (bad != 0) $display("  first mismatch at word %0d: %h vs %h", first, mem[first], exp_mem[first]);
    endtask

    task automatic run_chain(input logic [31:0] head, input bit poke, input string tag, output int reqs);
        bit e_err; int e_fail, e_cnt, rises0, reqs0, t;
        logic [31:0] v;
        model_run(head, e_err, e_fail, e_cnt);
        rises0 = irq_rises; reqs0 = req_cycles;
        reg_write(RIX_HEAD, head);
        run_active = 1'b1;
        #1 check(reg_rdata[SB_BUSY] == 1'b1, "R5 busy after start", reg_rdata, 32'd1);
        if (poke) begin
            reg_write(RIX_HEAD, 32'h0000_0F00);
            reg_read(RIX_HEAD, v);
            check(v == head, "R6 start while busy ignored", v, head);
        end
        t = 0;
        while (!irq_o && t < 40000) begin @(negedge clk); t++; end
        check(irq_o == 1'b1, {"R7 completion ", tag}, {31'd0, irq_o}, 32'd1);
        run_active = 1'b0;
        @(negedge clk);
        reg_read(RIX_STAT, v);
        check(v == {29'd0, e_err, 1'b1, 1'b0}, {"R8 status ", tag}, v, {29'd0, e_err, 2'b10});
        reg_read(RIX_FAIL, v);
        check(v == 32'(e_fail), {"R8 failing index ", tag}, v, 32'(e_fail));
        reg_read(RIX_CNT, v);
        check(v == 32'(e_cnt), {"R9 count ", tag}, v, 32'(e_cnt));
        check(irq_rises == rises0 + 1, {"R7 single interrupt ", tag}, 32'(irq_rises - rises0), 32'd1);
        compare_mem({"R4 memory image ", tag});
        reg_write(RIX_STAT, 32'd0);
        #1 check(irq_o == 1'b1, "R7 irq kept on write without bit1", {31'd0, irq_o}, 32'd1);
        reg_write(RIX_STAT, 32'd2);
        #1 check(irq_o == 1'b0, "R7 irq cleared", {31'd0, irq_o}, 32'd0);
        reqs = req_cycles - reqs0;
    endtask

    initial begin
        logic [31:0] v;
        int reqs;
        for (int i = 0; i < MEMW; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        for (int i = 0; i < NB*BLK_WORDS; i++) exp_store[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        reg_read(RIX_STAT, v); check(v == 32'd0, "R5 reset status", v, 32'd0);
        reg_read(RIX_HEAD, v); check(v == 32'd0, "R6 reset head", v, 32'd0);
        reg_read(RIX_CNT, v);  check(v == 32'd0, "R9 reset count", v, 32'd0);
        check(irq_o == 1'b0, "R7 reset irq", {31'd0, irq_o}, 32'd0);

        for (int b = 0; b < 8; b++) fill_buf(32'h1000 + 32'(b*512), b + 1);

        // R3 R1: two block writes, extra op bits set to show they are ignored (R2)
        put_node(32'h100, 32'h0000_00F1, 0, 32'h1000, 32'h110);
        put_node(32'h110, 32'h1, 1, 32'h1200, 32'h0);
        run_chain(32'h100, 1'b0, "writes", reqs);

        // R2 R4: mixed list, write then read-back of the same block; start poked while busy (R6)
        put_node(32'h200, 32'h0, 1, 32'h1400, 32'h210);
        put_node(32'h210, 32'h1, 2, 32'h1600, 32'h220);
        put_node(32'h220, 32'hFFFF_FFFE, 2, 32'h1800, 32'h230);
        put_node(32'h230, 32'h0, 0, 32'h1A00, 32'h0);
        run_chain(32'h200, 1'b1, "mixed", reqs);

        // R11: same kind of traffic under a stalling memory
        stall_en = 1'b1;
        fill_buf(32'h1C00, 40);
        put_node(32'h300, 32'h1, 3, 32'h1C00, 32'h310);
        put_node(32'h310, 32'h0, 3, 32'h1E00, 32'h320);
        put_node(32'h320, 32'h0, 1, 32'h1400, 32'h0);
        run_chain(32'h300, 1'b0, "stalled", reqs);

        // R8: out-of-range block at entry 1 stops the list, entry 2 untouched
        fill_buf(32'h2000, 77);
        put_node(32'h400, 32'h0, 2, 32'h2200, 32'h410);
        put_node(32'h410, 32'h1, NB, 32'h1000, 32'h420);
        put_node(32'h420, 32'h0, 0, 32'h2000, 32'h0);
        run_chain(32'h400, 1'b0, "bad block", reqs);

        // R8: a fresh start clears the error
        stall_en = 1'b0;
        put_node(32'h500, 32'h0, 0, 32'h2400, 32'h0);
        run_chain(32'h500, 1'b0, "after error", reqs);

        // R10: empty list
        run_chain(32'h0, 1'b0, "empty", reqs);
        check(reqs == 0, "R10 no memory traffic", 32'(reqs), 32'd0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule